// File: doc/BRIEF.md
# Interrupt Gateway with Claim/Complete Lockout

This block is the front end of a platform-level interrupt controller. It holds one gateway slice for each interrupt source. Each slice turns a raw, already synchronised interrupt line into a pending bit. A per-source mode bit chooses between level and edge sensing.

When a target claims a source, that source's pending bit is cleared and the source enters service. While it is in service, new activity on its line cannot make it pend again. The lockout ends when a completion carrying the same source ID arrives. Claims and completions are single-cycle strobes, each paired with a source ID. ID 0 is reserved. Source ID k is carried on bit k-1 of every per-source vector.

Priority selection, enables and the register interface sit outside this block. The block consumes the claim and complete strobes that those parts produce, and it hands back only the pending vector.

Top module: `irq_gateway`

## Requirements
- R1: With its mode bit at 0 (level), a source whose input is 1 in a cycle, that is not in service and not being claimed, shows pending = 1 after the next rising clock edge.
- R2: With its mode bit at 1 (edge), a source pends after the clock edge at which its input is 1 and its previous sample was 0. An input held high produces only one trigger.
- R3: A trigger that occurs in the same cycle as a claim of that source does not set its pending bit. The claim also places the source in service, even when it was not pending.
- R4: A set pending bit stays 1 until its source is claimed. A low input or a missing edge does not clear it.
- R5: A claim strobe whose ID names a source clears that source's pending bit at the next clock edge and leaves the other sources' bits unchanged.
- R6: A claimed source does not pend again while in service, even with its input held high. A completion carrying a different ID does not end the lockout.
- R7: A completion with a matching ID ends service at the next clock edge. A level source whose input is still high then pends one edge later.
- R8: Claim or complete strobes carrying ID 0, or an ID greater than the number of sources, affect no source.
- R9: After reset all pending bits are 0. An edge-mode input that is high when reset is released counts as a rising edge.
- R10: The previous-sample register keeps tracking the input while the source is in service, so a rising edge that happens during service is not replayed after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NumSrc | Raw interrupt lines; bit k-1 belongs to source ID k |
| edgeMode | input | NumSrc | Per-source sensing mode: 0 level, 1 edge |
| claimStrobe | input | 1 | One-cycle claim request |
| claimId | input | IdW | Source ID that is being claimed |
| completeStrobe | input | 1 | One-cycle completion notice |
| completeId | input | IdW | Source ID that is being completed |
| pendingOut | output | NumSrc | Pending bit of each source |

## Verification
The hardest situations to create from the ports are the ones where two events meet in a single cycle. One is a trigger landing in the same cycle as a claim of its own source. Another is an edge arriving while the source is in service and then being followed by its completion. The stimulus reaches these cases deliberately. It raises an input in exactly the cycle that carries the claim strobe. It raises an edge-mode input during service and keeps it high through the completion, so a replayed edge would show up as a pending bit. Out-of-range and zero IDs are sent while another source is pending or locked, so any stray effect would be visible on the pending vector.

// File: rtl/irq_gateway_pkg.sv
package irq_gateway_pkg;

  // Per-source strobes handed from the decode control to each slice
  typedef struct packed {
    logic claimHit;
    logic completeHit;
  } gw_strobe_t;

endpackage

// File: rtl/irq_gateway_ctrl.sv
module irq_gateway_ctrl
  import irq_gateway_pkg::*;
#(
  parameter int NumSrc = 32,
  parameter int IdW    = $clog2(NumSrc + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    claimStrobe,
  input  logic [IdW-1:0]          claimId,
  input  logic                    completeStrobe,
  input  logic [IdW-1:0]          completeId,
  output gw_strobe_t [NumSrc-1:0] strobes
);

  logic [NumSrc-1:0] claimVec;
  logic [NumSrc-1:0] completeVec;

  // ID k drives slice k-1; ID 0 and IDs above NumSrc match nothing
  for (genvar k = 0; k < NumSrc; k++) begin : g_dec
    assign claimVec[k]    = claimStrobe    && (claimId    == IdW'(k + 1));
    assign completeVec[k] = completeStrobe && (completeId == IdW'(k + 1));
    assign strobes[k].claimHit    = claimVec[k];
    assign strobes[k].completeHit = completeVec[k];
  end

  // R8: a single ID can reach at most one slice
  p_claim_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(claimVec));
  p_complete_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(completeVec));
  // R8: reserved or out-of-range IDs reach no slice
  p_claim_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (claimId == '0 || int'(claimId) > NumSrc) |-> (claimVec == '0));
  p_complete_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (completeId == '0 || int'(completeId) > NumSrc) |-> (completeVec == '0));

endmodule

// File: rtl/irq_gateway_slice.sv
module irq_gateway_slice
  import irq_gateway_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcBit,
  input  logic       modeBit,
  input  gw_strobe_t strobe,
  output logic       pendingBit
);

  logic prevSample;
  logic inService;
  logic trigger;
  logic armOk;

  // Level mode passes the input through; edge mode needs a low-to-high step
  assign trigger = modeBit ? (srcBit & ~prevSample) : srcBit;
  assign armOk   = trigger & ~inService & ~strobe.claimHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= 1'b0;
      pendingBit <= 1'b0;
      inService  <= 1'b0;
    end else begin
      prevSample <= srcBit;
      if (strobe.claimHit)  pendingBit <= 1'b0;
      else if (armOk)       pendingBit <= 1'b1;
      if (strobe.claimHit)         inService <= 1'b1;
      else if (strobe.completeHit) inService <= 1'b0;
    end
  end

  p_level_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!modeBit && srcBit && !inService && !strobe.claimHit) |=> pendingBit);
  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeBit && srcBit && !prevSample && !inService && !strobe.claimHit) |=> pendingBit);
  p_claim_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.claimHit |=> inService);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendingBit && !strobe.claimHit) |=> pendingBit);
  p_claim_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.claimHit |=> !pendingBit);
  p_lockout_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !pendingBit) |=> !pendingBit);
  p_complete_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.completeHit && !strobe.claimHit) |=> !inService);
  p_track_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevSample == $past(srcBit)));

endmodule

// File: rtl/irq_gateway_datapath.sv
module irq_gateway_datapath
  import irq_gateway_pkg::*;
#(
  parameter int NumSrc = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic       [NumSrc-1:0] srcIn,
  input  logic       [NumSrc-1:0] edgeMode,
  input  gw_strobe_t [NumSrc-1:0] strobes,
  output logic       [NumSrc-1:0] pendingOut
);

  for (genvar k = 0; k < NumSrc; k++) begin : g_slice
    irq_gateway_slice u_slice (
      .clk        (clk),
      .rstN       (rstN),
      .srcBit     (srcIn[k]),
      .modeBit    (edgeMode[k]),
      .strobe     (strobes[k]),
      .pendingBit (pendingOut[k])
    );
  end

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
  import irq_gateway_pkg::*;
#(
  parameter int NumSrc = 32,
  parameter int IdW    = $clog2(NumSrc + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcIn,
  input  logic [NumSrc-1:0] edgeMode,
  input  logic              claimStrobe,
  input  logic [IdW-1:0]    claimId,
  input  logic              completeStrobe,
  input  logic [IdW-1:0]    completeId,
  output logic [NumSrc-1:0] pendingOut
);

  gw_strobe_t [NumSrc-1:0] strobes;

  irq_gateway_ctrl #(.NumSrc(NumSrc), .IdW(IdW)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .claimStrobe    (claimStrobe),
    .claimId        (claimId),
    .completeStrobe (completeStrobe),
    .completeId     (completeId),
    .strobes        (strobes)
  );

  irq_gateway_datapath #(.NumSrc(NumSrc)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcIn      (srcIn),
    .edgeMode   (edgeMode),
    .strobes    (strobes),
    .pendingOut (pendingOut)
  );

  // R9: nothing pends in the cycle after reset is released
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (pendingOut == '0));

endmodule

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;
  localparam int N   = 4;
  localparam int IdW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   srcIn = '0;
  logic [N-1:0]   edgeMode = 4'b1010; // IDs 2 and 4 edge, IDs 1 and 3 level
  logic           claimStrobe = 1'b0;
  logic [IdW-1:0] claimId = '0;
  logic           completeStrobe = 1'b0;
  logic [IdW-1:0] completeId = '0;
  logic [N-1:0]   pendingOut;

  int testCount = 0;
  int failCount = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  irq_gateway #(.NumSrc(N)) u_irq_gateway (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .edgeMode(edgeMode),
    .claimStrobe(claimStrobe), .claimId(claimId),
    .completeStrobe(completeStrobe), .completeId(completeId),
    .pendingOut(pendingOut)
  );

  // Driver: one cycle of stimulus plus the pending vector expected after that edge
  task automatic step(input logic [N-1:0] src,
                      input logic cs, input int cid,
                      input logic ps, input int pid,
                      input logic [N-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    srcIn = src;
    claimStrobe = cs;   claimId = IdW'(cid);
    completeStrobe = ps; completeId = IdW'(pid);
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        testCount++;
        if (pendingOut !== it.exp) begin
          failCount++;
          $display("FAIL %s: pendingOut=%b expected=%b", it.tag, pendingOut, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    srcIn = 4'b1000; // ID4 (edge) held high through reset
    repeat (3) @(negedge clk);
    testCount++;
    if (pendingOut !== '0) begin
      failCount++;
      $display("FAIL R9 reset: pendingOut=%b expected=%b", pendingOut, 4'b0000);
    end
    rstN = 1'b1;
    // R9: high input out of reset is an edge
    step(4'b1000, 0, 0, 0, 0, 4'b1000, "R9 edge after reset");
    step(4'b1000, 0, 0, 0, 0, 4'b1000, "R2 steady high no retrigger");
    step(4'b0000, 0, 0, 0, 0, 4'b1000, "R4 input low keeps pending");
    step(4'b0000, 1, 4, 0, 0, 4'b0000, "R5 claim ID4 clears");
    step(4'b1000, 0, 0, 0, 0, 4'b0000, "R6 edge during service ignored");
    step(4'b1000, 0, 0, 1, 4, 0000,    "R10 edge not replayed at complete");
    step(4'b1000, 0, 0, 0, 0, 4'b0000, "R10 edge not replayed after complete");
    step(4'b0000, 0, 0, 0, 0, 4'b0000, "R2 low");
    step(4'b1000, 0, 0, 0, 0, 4'b1000, "R2 fresh edge after complete");
    step(4'b0000, 1, 4, 0, 0, 4'b0000, "R5 claim ID4");
    step(4'b0000, 0, 0, 1, 4, 4'b0000, "R7 complete ID4");
    // Level source ID1
    step(4'b0001, 0, 0, 0, 0, 4'b0001, "R1 level pends");
    step(4'b0001, 1, 1, 0, 0, 4'b0000, "R5 claim ID1 while high");
    step(4'b0001, 0, 0, 0, 0, 4'b0000, "R6 locked while high");
    step(4'b0001, 0, 0, 1, 2, 4'b0000, "R6 wrong ID complete");
    step(4'b0001, 0, 0, 0, 0, 4'b0000, "R6 still locked");
    step(4'b0001, 0, 0, 1, 1, 4'b0000, "R7 complete edge gated");
    step(4'b0001, 0, 0, 0, 0, 4'b0001, "R7 level repends");
    step(4'b0000, 1, 1, 0, 0, 4'b0000, "R5 claim ID1");
    step(4'b0000, 0, 0, 1, 1, 4'b0000, "R7 complete ID1");
    // R3: trigger and claim in the same cycle, level ID3
    step(4'b0100, 1, 3, 0, 0, 4'b0000, "R3 level trigger with claim");
    step(4'b0100, 0, 0, 0, 0, 4'b0000, "R3 claim placed ID3 in service");
    step(4'b0000, 0, 0, 1, 3, 4'b0000, "R7 complete ID3");
    step(4'b0100, 0, 0, 0, 0, 4'b0100, "R1 ID3 pends normally");
    step(4'b0000, 1, 3, 0, 0, 4'b0000, "R5 claim ID3");
    step(4'b0000, 0, 0, 1, 3, 4'b0000, "R7 complete ID3");
    // R3: edge ID2 with claim in the same cycle
    step(4'b0010, 1, 2, 0, 0, 4'b0000, "R3 edge trigger with claim");
    step(4'b0010, 0, 0, 1, 2, 4'b0000, "R7 complete ID2");
    step(4'b0010, 0, 0, 0, 0, 4'b0000, "R3 edge consumed");
    step(4'b0000, 0, 0, 0, 0, 4'b0000, "R2 low");
    step(4'b0010, 0, 0, 0, 0, 4'b0010, "R2 new edge ID2");
    step(4'b0000, 1, 2, 0, 0, 4'b0000, "R5 claim ID2");
    step(4'b0000, 0, 0, 1, 2, 4'b0000, "R7 complete ID2");
    // R8: reserved and out-of-range IDs
    step(4'b0001, 0, 0, 0, 0, 4'b0001, "R1 ID1 pends");
    step(4'b0000, 1, 0, 0, 0, 4'b0001, "R8 claim ID0 ignored");
    step(4'b0000, 1, 7, 0, 0, 4'b0001, "R8 claim ID7 ignored");
    step(4'b0000, 1, 5, 0, 0, 4'b0001, "R8 claim ID5 ignored");
    step(4'b0001, 1, 1, 0, 0, 4'b0000, "R5 claim ID1");
    step(4'b0001, 0, 0, 1, 0, 4'b0000, "R8 complete ID0 ignored");
    step(4'b0001, 0, 0, 1, 5, 4'b0000, "R8 complete ID5 ignored");
    step(4'b0001, 0, 0, 0, 0, 4'b0000, "R8 ID1 still locked");
    step(4'b0001, 0, 0, 1, 1, 4'b0000, "R7 complete ID1");
    step(4'b0001, 0, 0, 0, 0, 4'b0001, "R7 ID1 repends");
    // All sources together, then a claim that touches one only
    step(4'b1111, 0, 0, 0, 0, 4'b1111, "R1 R2 all pend");
    step(4'b1111, 1, 3, 0, 0, 4'b1011, "R5 claim ID3 only");
    step(4'b0000, 0, 0, 0, 0, 4'b1011, "R4 others hold");
    step(4'b0000, 0, 0, 0, 0, 4'b1011, "R4 idle");
    @(negedge clk);
    claimStrobe = 1'b0; completeStrobe = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule